// File: doc/BRIEF.md
# Serial Transmit/Receive Engine with Byte Queues

This block turns bytes into asynchronous serial frames and back. Bytes to send are written into an eight-entry transmit queue with a write strobe. While transmission is enabled, the transmit shifter pulls them out one at a time and sends each one as a frame. A frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. The receive side synchronises the incoming line and finds the start of a frame. It samples every bit near its middle and places each good byte in an eight-entry receive queue. The head byte of that queue is always visible, and a read strobe removes it.

A register front end outside this block drives the controls: an enable for each direction, an interrupt enable for each of two queue conditions, one-cycle flush pulses for each queue, and a 16-bit divisor that gives the bit period in clock cycles. After reset that front end loads the divisor with 217. The block reports full, empty and idle state for both directions and drives one level interrupt.

Top module: `uart_fifo_core`

## Requirements
- R1: During and right after a synchronous reset: both queues are empty and not full, both idle flags are 1, `ser_out` is 1 and `irq` is 0.
- R2: A sent frame is a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. Each bit lasts `baud_div` clock cycles, and the line rests at 1 between frames.
- R3: No frame starts while `tx_enable` is 0. Queued bytes wait and `ser_out` stays 1.
- R4: The transmit queue holds 8 bytes and raises `tx_full` when it holds 8. A `tx_wr` while it is full is dropped, so that byte is never sent.
- R5: With `rx_enable` set, a frame on `ser_in` with a high stop bit puts its byte in the receive queue. `rx_rdata` shows the oldest byte while `rx_empty` is 0, and `rx_rd` removes it. Bytes leave in the order they arrived.
- R6: While `rx_enable` is 0, frames on `ser_in` are ignored, `rx_idle` stays 1 and the receive queue is left as it is.
- R7: The receive queue holds 8 bytes and raises `rx_full` when it holds 8. A byte that completes while the queue is full is discarded.
- R8: A received frame whose stop bit samples as 0 is discarded.
- R9: A `tx_flush` or `rx_flush` pulse empties its queue by the next cycle. A write to that queue in the same cycle is ignored.
- R10: `irq` is registered. One cycle after an input change it equals (`irq_txe_en` AND `tx_empty`) OR (`irq_rxne_en` AND NOT `rx_empty`).
- R11: `tx_idle` is 1 only when the shifter is not sending and the transmit queue is empty. `rx_idle` is 0 while the receiver is inside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Allows frames to start |
| rx_enable | input | 1 | Allows frames to be received |
| irq_txe_en | input | 1 | Interrupt on transmit queue empty |
| irq_rxne_en | input | 1 | Interrupt on receive queue holding data |
| tx_flush | input | 1 | One-cycle pulse that empties the transmit queue |
| rx_flush | input | 1 | One-cycle pulse that empties the receive queue |
| baud_div | input | 16 | Bit period in clock cycles |
| tx_wr | input | 1 | Pushes `tx_wdata` into the transmit queue |
| tx_wdata | input | 8 | Byte to send |
| rx_rd | input | 1 | Pops the receive queue head |
| rx_rdata | output | 8 | Receive queue head byte |
| tx_full | output | 1 | Transmit queue holds 8 bytes |
| rx_full | output | 1 | Receive queue holds 8 bytes |
| tx_empty | output | 1 | Transmit queue is empty |
| rx_empty | output | 1 | Receive queue is empty |
| tx_idle | output | 1 | Nothing queued and nothing being sent |
| rx_idle | output | 1 | Receiver is outside a frame |
| irq | output | 1 | Level interrupt |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |

## Verification
A queue pointer or count that goes wrong shows up within one cycle in the full and empty flags. After that it shows as wrong, reordered or repeated bytes at `rx_rdata`, or as a byte that should have been dropped and is sent anyway. A fault in the bit counters or the divisor compare skews the bit timing. Checking `ser_out` at every bit midpoint catches this within one frame of `baud_div` times ten cycles, and a wrong sampling point on the receive side corrupts looped-back bytes in that same frame. A wrong stop-bit or overflow rule shows as a stray or missing byte at the receive queue once its frame has ended.

// File: rtl/uart_core_pkg.sv
package uart_core_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned DIV_W      = 16;
  localparam int unsigned FRAME_BITS = DATA_W + 2;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int unsigned AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rd_ptr];

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_data,
  output logic              q_pop,
  output logic              ser_out,
  output logic              busy
);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS + 1);

  logic [DATA_W:0]  shreg;
  logic [DIV_W-1:0] cnt;
  logic [BIT_W-1:0] bitn;
  logic [DIV_W:0]   cnt_inc;
  logic             bit_end;

  assign cnt_inc = {1'b0, cnt} + {{DIV_W{1'b0}}, 1'b1};
  assign bit_end = (cnt_inc >= {1'b0, div});
  assign q_pop   = !busy && enable && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      ser_out <= 1'b1;
      shreg   <= '0;
      cnt     <= '0;
      bitn    <= '0;
    end else if (q_pop) begin
      busy    <= 1'b1;
      ser_out <= 1'b0;                // start bit
      shreg   <= {1'b1, q_data};      // stop bit above the data
      cnt     <= '0;
      bitn    <= '0;
    end else if (busy) begin
      if (bit_end) begin
        cnt <= '0;
        if (bitn == BIT_W'(FRAME_BITS - 1)) begin
          busy <= 1'b0;
        end else begin
          ser_out <= shreg[0];
          shreg   <= {1'b0, shreg[DATA_W:1]};
          bitn    <= bitn + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div,
  input  logic              ser_in,
  output logic              push,
  output logic [DATA_W-1:0] pdata,
  output logic              in_frame
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  rx_state_e         state;
  logic [1:0]        sync;
  logic              line;
  logic [DIV_W-1:0]  cnt;
  logic [IDX_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic [DIV_W:0]    cnt_inc;
  logic              half_end, full_end;

  assign line     = sync[1];
  assign cnt_inc  = {1'b0, cnt} + {{DIV_W{1'b0}}, 1'b1};
  assign half_end = (cnt_inc >= {2'b00, div[DIV_W-1:1]});
  assign full_end = (cnt_inc >= {1'b0, div});
  assign in_frame = (state != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], ser_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      push  <= 1'b0;
      pdata <= '0;
    end else begin
      push <= 1'b0;
      if (!enable) begin
        state <= RX_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          RX_IDLE: begin
            cnt <= '0;
            if (!line) state <= RX_START;
          end
          RX_START: begin
            if (half_end) begin
              cnt   <= '0;
              bitn  <= '0;
              state <= line ? RX_IDLE : RX_DATA;
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: begin
            if (full_end) begin
              cnt   <= '0;
              shreg <= {line, shreg[DATA_W-1:1]};
              bitn  <= bitn + 1'b1;
              if (bitn == IDX_W'(DATA_W - 1)) state <= RX_STOP;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: begin
            if (full_end) begin
              cnt   <= '0;
              state <= RX_IDLE;
              if (line) begin
                push  <= 1'b1;
                pdata <= shreg;
              end
            end else cnt <= cnt + 1'b1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core
  import uart_core_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_enable,
  input  logic              rx_enable,
  input  logic              irq_txe_en,
  input  logic              irq_rxne_en,
  input  logic              tx_flush,
  input  logic              rx_flush,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              tx_full,
  output logic              rx_full,
  output logic              tx_empty,
  output logic              rx_empty,
  output logic              tx_idle,
  output logic              rx_idle,
  output logic              irq,
  input  logic              ser_in,
  output logic              ser_out
);
  logic [DATA_W-1:0] txq_head, rx_byte;
  logic              txq_pop, tx_busy, rx_push, rx_in_frame;

  uart_sync_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_wr), .wdata(tx_wdata),
    .pop(txq_pop), .rdata(txq_head),
    .full(tx_full), .empty(tx_empty)
  );

  uart_tx_engine i_tx (
    .clk(clk), .rst(rst), .enable(tx_enable), .div(baud_div),
    .q_empty(tx_empty || tx_flush), .q_data(txq_head), .q_pop(txq_pop),
    .ser_out(ser_out), .busy(tx_busy)
  );

  uart_rx_engine i_rx (
    .clk(clk), .rst(rst), .enable(rx_enable), .div(baud_div),
    .ser_in(ser_in), .push(rx_push), .pdata(rx_byte), .in_frame(rx_in_frame)
  );

  uart_sync_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rx_push), .wdata(rx_byte),
    .pop(rx_rd), .rdata(rx_rdata),
    .full(rx_full), .empty(rx_empty)
  );

  assign tx_idle = !tx_busy && tx_empty;
  assign rx_idle = !rx_in_frame;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (irq_txe_en && tx_empty) || (irq_rxne_en && !rx_empty);
  end
endmodule

// File: rtl/uart_fifo_core_chk.sv
module uart_fifo_core_chk (
  input logic clk,
  input logic rst,
  input logic tx_enable,
  input logic rx_enable,
  input logic irq_txe_en,
  input logic irq_rxne_en,
  input logic tx_flush,
  input logic rx_flush,
  input logic tx_wr,
  input logic tx_full,
  input logic rx_full,
  input logic tx_empty,
  input logic rx_empty,
  input logic tx_idle,
  input logic rx_idle,
  input logic irq,
  input logic ser_out
);
  // R11: nothing is being sent while idle, so the line rests high (R2)
  a_r11_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    tx_idle |-> ser_out);

  // R3: with transmission disabled and idle, the line cannot drop
  a_r3_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
    (!tx_enable && tx_idle) |=> ser_out);

  // R4: a write to a full, blocked queue leaves it full
  a_r4_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (tx_full && tx_wr && !tx_enable && !tx_flush) |=> tx_full);

  // R9: flush pulses empty their queue
  a_r9_tx_flush_empties: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> tx_empty);
  a_r9_rx_flush_empties: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> rx_empty);

  // R6: a disabled receiver never enters a frame
  a_r6_rx_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !rx_enable |=> rx_idle);

  // R7: full and empty are exclusive
  a_r7_rx_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(rx_full && rx_empty));
  a_r4_tx_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(tx_full && tx_empty));

  // R10: no enable in the previous cycle, no interrupt
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $past(!irq_txe_en && !irq_rxne_en) |-> !irq);
endmodule

bind uart_fifo_core uart_fifo_core_chk i_chk (
  .clk(clk), .rst(rst), .tx_enable(tx_enable), .rx_enable(rx_enable),
  .irq_txe_en(irq_txe_en), .irq_rxne_en(irq_rxne_en),
  .tx_flush(tx_flush), .rx_flush(rx_flush), .tx_wr(tx_wr),
  .tx_full(tx_full), .rx_full(rx_full), .tx_empty(tx_empty),
  .rx_empty(rx_empty), .tx_idle(tx_idle), .rx_idle(rx_idle),
  .irq(irq), .ser_out(ser_out)
);

// File: tb/test_uart_fifo_core.sv
module test_uart_fifo_core;
  localparam int DIV = 16;
  localparam int NVEC = 6;
  // {byte written, byte expected back}
  localparam logic [15:0] VEC [NVEC] = '{16'h5555, 16'hA3A3, 16'h0000,
                                         16'hFFFF, 16'h8181, 16'h3C3C};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_enable = 1'b0, rx_enable = 1'b0;
  logic irq_txe_en = 1'b0, irq_rxne_en = 1'b0;
  logic tx_flush = 1'b0, rx_flush = 1'b0;
  logic [15:0] baud_div = 16'(DIV);
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_wdata = 8'h00;
  logic [7:0] rx_rdata;
  logic tx_full, rx_full, tx_empty, rx_empty, tx_idle, rx_idle, irq;
  logic ser_in, ser_out;
  logic loop_en = 1'b0, drv_line = 1'b1;
  logic mid_idle;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign ser_in = loop_en ? ser_out : drv_line;

  always #5 clk = ~clk;

  uart_fifo_core i_uart_fifo_core (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .irq_txe_en(irq_txe_en), .irq_rxne_en(irq_rxne_en),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .baud_div(baud_div),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .tx_full(tx_full), .rx_full(rx_full), .tx_empty(tx_empty),
    .rx_empty(rx_empty), .tx_idle(tx_idle), .rx_idle(rx_idle), .irq(irq),
    .ser_in(ser_in), .ser_out(ser_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] b);
    tx_wr = 1'b1; tx_wdata = b;
    cyc(1);
    tx_wr = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    b = rx_rdata;
    rx_rd = 1'b1;
    cyc(1);
    rx_rd = 1'b0;
  endtask

  task automatic wait_rx(input string tag);
    int t;
    t = 0;
    while (rx_empty && t < 20 * DIV) begin cyc(1); t++; end
    if (rx_empty) chk(tag, 32'(rx_empty), 32'd0);
  endtask

  task automatic wait_tx_idle(input int limit);
    int t;
    t = 0;
    while (!tx_idle && t < limit) begin cyc(1); t++; end
  endtask

  // drives one frame on ser_in; stop_len cycles of the stop level
  task automatic drive_frame(input logic [7:0] b, input logic stop_v, input int stop_len);
    drv_line = 1'b0; cyc(DIV);
    for (int i = 0; i < 8; i++) begin
      drv_line = b[i];
      cyc(DIV / 2);
      if (i == 4) mid_idle = rx_idle;
      cyc(DIV - DIV / 2);
    end
    drv_line = stop_v; cyc(stop_len);
    drv_line = 1'b1; cyc(DIV);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    logic low_seen;
    int t;

    cyc(3);
    // R1: flags {tx_full,rx_full,tx_empty,rx_empty,tx_idle,rx_idle,ser_out,irq}
    chk("R1 in reset", {tx_full, rx_full, tx_empty, rx_empty, tx_idle, rx_idle, ser_out, irq}, 8'b0011_1110);
    rst = 1'b0;
    cyc(1);
    chk("R1 after reset", {tx_full, rx_full, tx_empty, rx_empty, tx_idle, rx_idle, ser_out, irq}, 8'b0011_1110);

    // R3 / R11: byte waits while tx disabled
    push_tx(8'h5A);
    cyc(1);
    chk("R11 tx_idle with queued byte", 32'(tx_idle), 0);
    low_seen = 0;
    for (int i = 0; i < 3 * DIV; i++) begin cyc(1); if (!ser_out) low_seen = 1; end
    chk("R3 line held while disabled", 32'(low_seen), 0);
    chk("R3 byte still queued", 32'(tx_empty), 0);

    // R2: frame shape on ser_out
    tx_enable = 1'b1;
    t = 0;
    while (ser_out && t < 10 * DIV) begin cyc(1); t++; end
    cyc(DIV / 2);
    chk("R2 start bit", 32'(ser_out), 0);
    got = 8'h00;
    for (int i = 0; i < 8; i++) begin cyc(DIV); got[i] = ser_out; end
    chk("R2 data LSB first", 32'(got), 32'h5A);
    cyc(DIV);
    chk("R2 stop bit", 32'(ser_out), 1);
    cyc(DIV);
    chk("R11 tx_idle after frame", 32'(tx_idle), 1);
    chk("R6 no reception while disabled (loop off)", 32'(rx_empty), 1);

    // R5: vector table through loopback
    loop_en = 1'b1; rx_enable = 1'b1;
    cyc(2);
    for (int v = 0; v < NVEC; v++) begin
      push_tx(VEC[v][15:8]);
      wait_rx("R5 byte arrives");
      pop_rx(got);
      chk("R5 loopback byte", 32'(got), 32'(VEC[v][7:0]));
    end

    // R4: fill tx queue past capacity
    tx_enable = 1'b0;
    for (int i = 0; i < 9; i++) push_tx(8'h10 + 8'(i));
    chk("R4 tx_full", 32'(tx_full), 1);
    tx_enable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wait_rx("R4 drained byte");
      pop_rx(got);
      chk("R4 order", 32'(got), 32'(8'h10 + 8'(i)));
    end
    cyc(12 * DIV);
    chk("R4 ninth byte dropped", 32'(rx_empty), 1);

    // R7: overflow of the rx queue
    for (int i = 0; i < 8; i++) push_tx(8'h20 + 8'(i));
    wait_tx_idle(100 * DIV);
    push_tx(8'h99);
    wait_tx_idle(20 * DIV);
    cyc(DIV);
    chk("R7 rx_full", 32'(rx_full), 1);
    for (int i = 0; i < 8; i++) begin
      pop_rx(got);
      chk("R7 kept bytes", 32'(got), 32'(8'h20 + 8'(i)));
    end
    chk("R7 overflow byte discarded", 32'(rx_empty), 1);

    // R8 / R11: bench-driven frames
    loop_en = 1'b0; drv_line = 1'b1;
    cyc(DIV);
    drive_frame(8'h3C, 1'b0, (3 * DIV) / 4);
    cyc(2 * DIV);
    chk("R8 bad stop discarded", 32'(rx_empty), 1);
    drive_frame(8'hC3, 1'b1, DIV);
    chk("R11 rx_idle low inside frame", 32'(mid_idle), 0);
    chk("R8 good frame after bad", 32'(rx_rdata), 32'hC3);
    pop_rx(got);

    // R6: receiver disabled
    rx_enable = 1'b0;
    drive_frame(8'h77, 1'b1, DIV);
    chk("R6 rx_idle during ignored frame", 32'(mid_idle), 1);
    chk("R6 nothing stored", 32'(rx_empty), 1);

    // R9: flushes, with a write in the flush cycle
    rx_enable = 1'b1; tx_enable = 1'b0;
    for (int i = 0; i < 3; i++) push_tx(8'h40 + 8'(i));
    tx_flush = 1'b1; tx_wr = 1'b1; tx_wdata = 8'hEE;
    cyc(1);
    tx_flush = 1'b0; tx_wr = 1'b0;
    chk("R9 tx flush empties", 32'(tx_empty), 1);
    tx_enable = 1'b1;
    cyc(2);
    chk("R9 flushed write not sent", 32'(tx_idle), 1);
    drive_frame(8'h11, 1'b1, DIV);
    drive_frame(8'h12, 1'b1, DIV);
    chk("R9 rx holds data", 32'(rx_empty), 0);
    rx_flush = 1'b1;
    cyc(1);
    rx_flush = 1'b0;
    chk("R9 rx flush empties", 32'(rx_empty), 1);

    // R10: interrupt conditions
    irq_txe_en = 1'b1;
    cyc(1);
    chk("R10 tx empty irq", 32'(irq), 1);
    irq_txe_en = 1'b0;
    cyc(1);
    chk("R10 irq off without enable", 32'(irq), 0);
    tx_enable = 1'b0;
    push_tx(8'h01);
    irq_txe_en = 1'b1;
    cyc(1);
    chk("R10 no irq with tx data", 32'(irq), 0);
    tx_flush = 1'b1; cyc(1); tx_flush = 1'b0;
    irq_txe_en = 1'b0; irq_rxne_en = 1'b1;
    cyc(1);
    chk("R10 no irq rx empty", 32'(irq), 0);
    drive_frame(8'h5E, 1'b1, DIV);
    cyc(1);
    chk("R10 rx data irq", 32'(irq), 1);
    pop_rx(got);
    cyc(1);
    chk("R10 irq clears after pop", 32'(irq), 0);
    chk("R5 popped byte", 32'(got), 32'h5E);

    finish_run();
  end
endmodule